// File: doc/BRIEF.md
# Interleaved Sample Stream Rate Divider

This block takes two 8-bit sample streams from a time-interleaved converter and slows each one down by a factor of four. The downstream storage can then accept them. Each port has an input register. That register feeds a bank of four holding registers in parallel. A divide-by-four counter launches a quarter-rate pulse into a short shift register. The taps of that shift register form a rotating one-hot load select, so each holding register takes every fourth sample and keeps it for four sample periods.

The design is modelled at the sample-clock rate. Both ports advance on the same clock edge, and each holding bank loads one cycle after its input register. In hardware the holding banks would load on the opposite clock edge; loading one cycle later gives the same settling margin.

For every loaded bank, a write strobe is raised a parameterised number of cycles later. The downstream memory then captures data that has already settled. Strobes can run continuously under an enable input. Alternatively, a trigger can start a single burst of a fixed length, which ends with a done flag.

Top module: `ilv_demux`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, all bank outputs, all write strobes and the done flag are zero. The first sample presented after reset goes to bank 0.
- R2: The k-th sample of port A after reset (counted from 0) is presented in the cycle before clock edge k+1. It appears in bank k mod 4 of `a_hold`, at bits [8*j+7 : 8*j] for bank j, in the cycle after edge k+2.
- R3: A loaded bank keeps its value for four cycles. In any cycle at most one bank per port changes.
- R4: Port B follows the same timing and bank mapping as port A, and carries its own data independently.
- R5: A write strobe for bank j sets bit j of `wr_stb` for one cycle. That cycle follows the clock edge that lies `OFFSET` (default 2) edges after the edge that loaded bank j. At most one strobe bit is set in any cycle, and no bit is set in two consecutive cycles.
- R6: With `burst_mode` low, a bank load is strobed exactly when `cap_en` is high at the edge that loads it.
- R7: With `burst_mode` high, a `burst_go` seen while no burst is running starts a burst. The next `BURST_LEN` (default 16) bank loads after that edge are strobed. `burst_go` during a running burst has no effect.
- R8: `burst_done` rises in the cycle after the last strobe of a burst. It stays high until a new burst is started, which clears it.
- R9: `cap_en` has no effect while `burst_mode` is high, and `burst_go` has no effect while `burst_mode` is low.
- R10: A memory that captures bank j on each strobe receives every permitted sample exactly once, in sample order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| a_smp | input | 8 | Port A sample |
| b_smp | input | 8 | Port B sample |
| cap_en | input | 1 | Continuous-mode write enable |
| burst_mode | input | 1 | Selects triggered burst capture |
| burst_go | input | 1 | Burst trigger |
| a_hold | output | 32 | Port A holding banks, bank j at bits [8j+7:8j] |
| b_hold | output | 32 | Port B holding banks |
| wr_stb | output | 4 | One-hot write strobe per bank |
| burst_done | output | 1 | Burst finished |

## Verification
The bench drives random data and checks on every cycle the bank contents, the strobes and the done flag. It also emulates a memory that pops samples on each strobe. The corner cases it targets, and how a faulty design would show up:
- Bank mapping right after reset: a divider that starts on the wrong phase would put sample 0 into a bank other than 0.
- Strobe offset: an off-by-one offset would capture a neighbouring sample, or would strobe after the bank has already changed.
- Enable toggling on single cycles: a design that samples the enable at the wrong edge would drop or duplicate writes.
- Burst triggers: a trigger that retriggers mid-burst, or a burst counter that is off by one, would show up in the write count and in the timing of the done flag.

// File: rtl/ilvd_pkg.sv
package ilvd_pkg;
  typedef enum logic {BST_IDLE = 1'b0, BST_RUN = 1'b1} bst_e;
endpackage

// File: rtl/ilvd_strobe_gen.sv
// Quarter-rate pulse from a wrapping divider, spread by a shift chain
// into a rotating one-hot bank select. All-zero after reset.
module ilvd_strobe_gen #(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NBANK-1:0] ld
);
  localparam int CW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [CW-1:0] div_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= (div_q == CW'(NBANK-1)) ? '0 : div_q + 1'b1;
      tick_q <= (div_q == '0);
    end
  end

  assign ld[0] = tick_q;

  for (genvar i = 1; i < NBANK; i++) begin : g_tap
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= ld[i-1];
    end
    assign ld[i] = q;
  end
endmodule

// File: rtl/ilvd_port_bank.sv
// One port: input register fanned out to NBANK holding registers.
module ilvd_port_bank #(
  parameter int DW    = 8,
  parameter int NBANK = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       smp,
  input  logic [NBANK-1:0]    ld,
  output logic [NBANK*DW-1:0] hold
);
  logic [DW-1:0] in_q;

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= smp;
  end

  for (genvar j = 0; j < NBANK; j++) begin : g_bank
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (ld[j]) q <= in_q;
    end
    assign hold[j*DW +: DW] = q;
  end
endmodule

// File: rtl/ilvd_write_align.sv
// Write permission (continuous or burst) and the delay line that
// places each bank's write strobe OFFSET edges after its load.
module ilvd_write_align
  import ilvd_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int OFFSET    = 2,
  parameter int BURST_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] ld,
  input  logic             cap_en,
  input  logic             burst_mode,
  input  logic             burst_go,
  output logic [NBANK-1:0] wr_stb,
  output logic             burst_done
);
  localparam int DEPTH = OFFSET + 1;
  localparam int LW    = $clog2(BURST_LEN + 1);

  bst_e          state;
  logic [LW-1:0] left_q;
  logic          loading, arm, perm, last_now;

  logic [NBANK-1:0] sel_q [DEPTH];
  logic [DEPTH-1:0] last_q;

  always_comb begin
    loading  = |ld;
    arm      = burst_mode && burst_go && (state == BST_IDLE);
    perm     = loading && (burst_mode ? (state == BST_RUN) : cap_en);
    last_now = burst_mode && (state == BST_RUN) && loading && (left_q == LW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= BST_IDLE;
      left_q <= '0;
    end else if (burst_mode && (state == BST_RUN) && loading) begin
      left_q <= left_q - 1'b1;
      if (left_q == LW'(1)) state <= BST_IDLE;
    end else if (arm) begin
      state  <= BST_RUN;
      left_q <= LW'(BURST_LEN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sel_q[i] <= '0;
      last_q <= '0;
    end else begin
      sel_q[0]  <= perm ? ld : '0;
      last_q[0] <= last_now;
      for (int i = 1; i < DEPTH; i++) begin
        sel_q[i]  <= sel_q[i-1];
        last_q[i] <= last_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     burst_done <= 1'b0;
    else if (arm)                burst_done <= 1'b0;
    else if (last_q[DEPTH-1])    burst_done <= 1'b1;
  end

  assign wr_stb = sel_q[DEPTH-1];
endmodule

// File: rtl/ilv_demux.sv
// Top: two ports sharing one bank-select generator and one write aligner.
// OFFSET must be below NBANK so the strobed bank is still unchanged.
module ilv_demux #(
  parameter int DW        = 8,
  parameter int NBANK     = 4,
  parameter int OFFSET    = 2,
  parameter int BURST_LEN = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       a_smp,
  input  logic [DW-1:0]       b_smp,
  input  logic                cap_en,
  input  logic                burst_mode,
  input  logic                burst_go,
  output logic [NBANK*DW-1:0] a_hold,
  output logic [NBANK*DW-1:0] b_hold,
  output logic [NBANK-1:0]    wr_stb,
  output logic                burst_done
);
  logic [NBANK-1:0] ld;

  ilvd_strobe_gen #(.NBANK(NBANK)) u_sel (
    .clk(clk), .rst(rst), .ld(ld)
  );

  ilvd_port_bank #(.DW(DW), .NBANK(NBANK)) u_pa (
    .clk(clk), .rst(rst), .smp(a_smp), .ld(ld), .hold(a_hold)
  );

  ilvd_port_bank #(.DW(DW), .NBANK(NBANK)) u_pb (
    .clk(clk), .rst(rst), .smp(b_smp), .ld(ld), .hold(b_hold)
  );

  ilvd_write_align #(.NBANK(NBANK), .OFFSET(OFFSET), .BURST_LEN(BURST_LEN)) u_wr (
    .clk(clk), .rst(rst), .ld(ld), .cap_en(cap_en), .burst_mode(burst_mode),
    .burst_go(burst_go), .wr_stb(wr_stb), .burst_done(burst_done)
  );
endmodule

// File: rtl/ilvd_chk.sv
module ilvd_chk #(
  parameter int DW    = 8,
  parameter int NBANK = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                burst_go,
  input logic [NBANK*DW-1:0] a_hold,
  input logic [NBANK*DW-1:0] b_hold,
  input logic [NBANK-1:0]    wr_stb,
  input logic                burst_done
);
  logic [NBANK*DW-1:0] prev_a, prev_b;
  logic                seen;
  logic [NBANK-1:0]    chg_a, chg_b;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
    prev_a <= a_hold;
    prev_b <= b_hold;
  end

  always_comb begin
    for (int j = 0; j < NBANK; j++) begin
      chg_a[j] = a_hold[j*DW +: DW] != prev_a[j*DW +: DW];
      chg_b[j] = b_hold[j*DW +: DW] != prev_b[j*DW +: DW];
    end
  end

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_stb == '0 && !burst_done));

  p_one_bank_a_r3: assert property (@(posedge clk) disable iff (rst)
    seen |-> $onehot0(chg_a));

  p_one_bank_b_r4: assert property (@(posedge clk) disable iff (rst)
    seen |-> $onehot0(chg_b));

  p_stb_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb));

  p_stb_no_repeat_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb & $past(wr_stb)) == '0);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (burst_done && !burst_go) |=> burst_done);

  p_done_after_stb_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_done) |-> $past(wr_stb) != '0);
endmodule

bind ilv_demux ilvd_chk #(.DW(DW), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst(rst), .burst_go(burst_go), .a_hold(a_hold), .b_hold(b_hold),
  .wr_stb(wr_stb), .burst_done(burst_done)
);

// File: tb/sim_ilv_demux.sv
`timescale 1ns/1ps
module sim_ilv_demux;
  localparam int DW = 8, NB = 4, OFF = 2, BL = 16, MX = 4200;

  logic clk = 1'b0, rst = 1'b1;
  logic [DW-1:0] a_smp = '0, b_smp = '0;
  logic cap_en = 1'b0, burst_mode = 1'b0, burst_go = 1'b0;
  logic [NB*DW-1:0] a_hold, b_hold;
  logic [NB-1:0] wr_stb;
  logic burst_done;

  ilv_demux #(.DW(DW), .NBANK(NB), .OFFSET(OFF), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .a_smp(a_smp), .b_smp(b_smp), .cap_en(cap_en),
    .burst_mode(burst_mode), .burst_go(burst_go), .a_hold(a_hold),
    .b_hold(b_hold), .wr_stb(wr_stb), .burst_done(burst_done)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural model state
  int n;
  int samp_a [MX], samp_b [MX];
  int exp_ha [NB], exp_hb [NB], prv_a [NB], prv_b [NB];
  bit ev_perm [MX], ev_last [MX];
  int ev_bank [MX];
  bit active, done;
  int left;
  int expq [$];

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, n);
    end
  endtask

  function automatic void model_clear();
    n = 0; active = 0; done = 0; left = 0;
    expq.delete();
    for (int i = 0; i < MX; i++) begin
      samp_a[i] = 0; samp_b[i] = 0; ev_perm[i] = 0; ev_last[i] = 0; ev_bank[i] = 0;
    end
    for (int j = 0; j < NB; j++) begin
      exp_ha[j] = 0; exp_hb[j] = 0; prv_a[j] = 0; prv_b[j] = 0;
    end
  endfunction

  function automatic void model_edge(int a, int b, bit en, bit bm, bit go);
    bit trig, perm, last;
    int k, j;
    n++;
    samp_a[n-1] = a; samp_b[n-1] = b;
    trig = bm && go && !active;
    if (trig) done = 0;
    else if (ev_perm[n-1] && ev_last[n-1]) done = 1;
    if (n >= 2) begin
      k = n - 2; j = k % NB;
      exp_ha[j] = samp_a[k]; exp_hb[j] = samp_b[k];
      perm = bm ? active : en;
      last = 0;
      if (bm && active) begin
        left--;
        if (left == 0) begin active = 0; last = 1; end
      end
      if (perm) begin
        ev_perm[n+OFF] = 1; ev_bank[n+OFF] = j; ev_last[n+OFF] = last;
        expq.push_back(k);
      end
    end
    if (trig) begin active = 1; left = BL; end
  endfunction

  task automatic compare(string wtag);
    int expw, nch_a, nch_b, k;
    nch_a = 0; nch_b = 0;
    for (int j = 0; j < NB; j++) begin
      chk("R2", int'(a_hold[j*DW +: DW]), exp_ha[j], "port A bank");
      chk("R4", int'(b_hold[j*DW +: DW]), exp_hb[j], "port B bank");
      if (int'(a_hold[j*DW +: DW]) != prv_a[j]) nch_a++;
      if (int'(b_hold[j*DW +: DW]) != prv_b[j]) nch_b++;
      prv_a[j] = int'(a_hold[j*DW +: DW]);
      prv_b[j] = int'(b_hold[j*DW +: DW]);
    end
    chk("R3", int'(nch_a <= 1 && nch_b <= 1), 1, "banks changed in one cycle");
    expw = ev_perm[n] ? (1 << ev_bank[n]) : 0;
    chk(wtag, int'(wr_stb), expw, "wr_stb");
    chk("R5", int'($countones(wr_stb) <= 1), 1, "strobe one-hot");
    chk("R8", int'(burst_done), int'(done), "burst_done");
    for (int j = 0; j < NB; j++) begin
      if (wr_stb[j]) begin
        if (expq.size() == 0) chk("R10", 1, 0, "unexpected memory write");
        else begin
          k = expq.pop_front();
          chk("R10", int'(a_hold[j*DW +: DW]), samp_a[k], "memory A word");
          chk("R10", int'(b_hold[j*DW +: DW]), samp_b[k], "memory B word");
        end
      end
    end
  endtask

  task automatic cyc(bit en, bit bm, bit go, string wtag);
    int a, b;
    a = int'($urandom_range(0, 255)); b = int'($urandom_range(0, 255));
    a_smp = DW'(a); b_smp = DW'(b);
    cap_en = en; burst_mode = bm; burst_go = go;
    @(posedge clk);
    @(negedge clk);
    model_edge(a, b, en, bm, go);
    compare(wtag);
  endtask

  task automatic do_reset();
    rst = 1; cap_en = 0; burst_mode = 0; burst_go = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(a_hold), 0, "A banks in reset");
    chk("R1", int'(b_hold), 0, "B banks in reset");
    chk("R1", int'(wr_stb), 0, "strobes in reset");
    chk("R1", int'(burst_done), 0, "done in reset");
    model_clear();
    rst = 0;
  endtask

  initial begin
    do_reset();
    // R1: first samples after reset, continuous capture (R5, R6)
    repeat (40) cyc(1'b1, 1'b0, 1'b0, "R5");
    // R6 + R9: enable toggling, trigger ignored in continuous mode
    repeat (60) cyc(1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)), "R6");
    repeat (8) cyc(1'b0, 1'b0, 1'b1, "R9");
    chk("R10", expq.size(), 0, "samples left unwritten after flush");
    chk("R9", int'(burst_done), 0, "trigger in continuous mode");
    // R7: burst with retriggers inside it (ignored) and cap_en noise (R9)
    cyc(1'b0, 1'b1, 1'b1, "R7");
    repeat (10) cyc(1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)), "R7");
    repeat (20) cyc(1'($urandom_range(0, 1)), 1'b1, 1'b0, "R9");
    chk("R8", int'(burst_done), 1, "done after burst");
    chk("R10", expq.size(), 0, "burst samples unwritten");
    // R8: second burst clears done
    cyc(1'b1, 1'b1, 1'b1, "R7");
    chk("R8", int'(burst_done), 0, "done cleared by new burst");
    repeat (25) cyc(1'b1, 1'b1, 1'b0, "R7");
    chk("R8", int'(burst_done), 1, "done after second burst");
    // R1: reset in the middle of a burst
    cyc(1'b0, 1'b1, 1'b1, "R7");
    repeat (5) cyc(1'b0, 1'b1, 1'b0, "R7");
    do_reset();
    repeat (24) cyc(1'b1, 1'b0, 1'b0, "R1");
    repeat (6) cyc(1'b0, 1'b0, 1'b0, "R6");
    chk("R10", expq.size(), 0, "samples left after restart");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule